// File: doc/BRIEF.md
# Descriptor Chain Walker

The walker serves one crypto channel. Software leaves a chain of 64-byte descriptors in system memory and hands the walker the address of the first one with a start pulse. The walker reads each descriptor word by word through a 32-bit request/response read port, with only one read in flight at a time. It decodes the header word into an engine category, a descriptor type, a count of active pointer/length pairs and a 16-bit engine-private control field. For every active pair it presents a transfer command on a valid/ready handshake. A command carries the data address, the byte length, the pair number, the direction, and the category, type and control field of its header.

Inside a descriptor, word 0 is the header, words 1 to 14 hold seven pointer/length pairs with the pointer first, and word 15 links to the next descriptor. A zero link ends the chain and raises the interrupt. A non-zero link starts a fetch of the next descriptor once every command of the current one has been accepted. If a header names an unknown category, or claims zero pairs, the walk stops at once and the interrupt comes up together with an error flag. The block does not move data or talk to the engines. Its output is the command stream.

Top module: `desc_walker`

## Requirements
- R1: After reset, and after a reset applied in the middle of a walk, `busy`, `rd_req`, `cmd_valid`, `irq` and `err` are all low.
- R2: A start pulse while idle begins reading at `start_ptr` with bits [1:0] forced to zero. Word k of a descriptor is read at base + 4·k in ascending order. A new `rd_req` never comes before the response `rd_rvalid` to the previous one.
- R3: Every command carries the header fields of its descriptor: `cmd_cat` = header[31:29], `cmd_type` = header[27:26], `cmd_ctrl` = header[15:0], the last passed through unmodified.
- R4: With N = header[18:16], exactly pairs 1..N produce commands, in ascending order. Pair p gives `cmd_idx` = p, `cmd_addr` = word 2p−1, `cmd_len` = word 2p bits [LEN_W−1:0] and `cmd_dir` = word 2p bit 31, where 1 means write to memory.
- R5: A command stays valid with all fields stable until `cmd_ready` is seen. No read is issued while a command is pending.
- R6: If word 15 is non-zero, the next descriptor is read from that value with bits [1:0] cleared. If word 15 is zero, the walk ends with `irq` high, `err` low and `busy` low.
- R7: A category tag of 000, 101, 110 or 111, or a pair count of zero, ends the walk right after the header read. No command is issued, and `irq` and `err` go high.
- R8: `irq` and `err` stay high until the next accepted start and clear on it. A start pulse seen while busy is ignored.
- R9: A valid descriptor is always read in full, all 16 words, even when fewer than seven pairs are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured only while idle |
| start_ptr | input | 32 | Address of the first descriptor |
| rd_req | output | 1 | One-cycle word read request |
| rd_addr | output | 32 | Word read address, valid with `rd_req` |
| rd_rvalid | input | 1 | Read data valid, one cycle per request |
| rd_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Transfer command accepted |
| cmd_addr | output | 32 | Data pointer of the pair |
| cmd_len | output | LEN_W | Byte length of the pair |
| cmd_idx | output | 3 | Pair number, 1 to 7 |
| cmd_dir | output | 1 | 1 = write to memory, 0 = read from memory |
| cmd_cat | output | 3 | Engine category tag |
| cmd_type | output | 2 | Descriptor type within the category |
| cmd_ctrl | output | 16 | Engine-private control halfword |
| busy | output | 1 | Walk in progress |
| irq | output | 1 | Chain finished, held until next start |
| err | output | 1 | Walk stopped on a bad header, held with `irq` |

## Verification
A word counter that is off by one shows up within one read cycle as a wrong `rd_addr`. It also swaps pointer and length on the next command, so `cmd_addr` and `cmd_len` hold each other's values. A pair-count comparison that is wrong adds or drops a command, and this appears at the count of commands seen before `irq` rises. A state machine that leaves the command state without a handshake shows a dropped or changed command on the first cycle `cmd_ready` is held low. A stuck link register shows as reads at the wrong base on the first word of the second descriptor.

// File: rtl/desc_walker.sv
`timescale 1ns/1ps
module desc_walker #(
  parameter int LEN_W   = 16,
  parameter int DIR_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      start_ptr,
  output logic             rd_req,
  output logic [31:0]      rd_addr,
  input  logic             rd_rvalid,
  input  logic [31:0]      rd_rdata,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [31:0]      cmd_addr,
  output logic [LEN_W-1:0] cmd_len,
  output logic [2:0]       cmd_idx,
  output logic             cmd_dir,
  output logic [2:0]       cmd_cat,
  output logic [1:0]       cmd_type,
  output logic [15:0]      cmd_ctrl,
  output logic             busy,
  output logic             irq,
  output logic             err
);
  localparam int WORDS = 16;
  localparam int WI_W  = $clog2(WORDS);
  localparam logic [WI_W-1:0] LAST = WI_W'(WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_CMD} st_t;

  st_t              st;
  logic [31:0]      base_q;
  logic [WI_W-1:0]  widx_q;
  logic [2:0]       cat_q;
  logic [1:0]       typ_q;
  logic [2:0]       np_q;
  logic [15:0]      ctl_q;
  logic [31:0]      ptr_q;
  logic [LEN_W-1:0] len_q;
  logic             dir_q;
  logic             irq_q;
  logic             err_q;

  logic [2:0] in_cat;
  logic       hdr_ok;
  logic       pair_used;
  logic       unused_lo;

  assign in_cat    = rd_rdata[31:29];
  assign hdr_ok    = (in_cat >= 3'd1) && (in_cat <= 3'd4) && (rd_rdata[18:16] != 3'd0);
  assign pair_used = widx_q[WI_W-1:1] <= np_q;
  assign unused_lo = ^start_ptr[1:0];

  assign rd_req    = (st == S_REQ);
  assign rd_addr   = base_q + {{(30-WI_W){1'b0}}, widx_q, 2'b00};
  assign cmd_valid = (st == S_CMD);
  assign cmd_addr  = ptr_q;
  assign cmd_len   = len_q;
  assign cmd_idx   = widx_q[WI_W-1:1];
  assign cmd_dir   = dir_q;
  assign cmd_cat   = cat_q;
  assign cmd_type  = typ_q;
  assign cmd_ctrl  = ctl_q;
  assign busy      = (st != S_IDLE);
  assign irq       = irq_q;
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base_q <= '0;
      widx_q <= '0;
      cat_q  <= '0;
      typ_q  <= '0;
      np_q   <= '0;
      ctl_q  <= '0;
      ptr_q  <= '0;
      len_q  <= '0;
      dir_q  <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base_q <= {start_ptr[31:2], 2'b00};
          widx_q <= '0;
          irq_q  <= 1'b0;
          err_q  <= 1'b0;
          st     <= S_REQ;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (rd_rvalid) begin
          if (widx_q == '0) begin
            cat_q <= in_cat;
            typ_q <= rd_rdata[27:26];
            np_q  <= rd_rdata[18:16];
            ctl_q <= rd_rdata[15:0];
            if (hdr_ok) begin
              widx_q <= widx_q + WI_W'(1);
              st     <= S_REQ;
            end else begin
              irq_q <= 1'b1;
              err_q <= 1'b1;
              st    <= S_IDLE;
            end
          end else if (widx_q == LAST) begin
            if (rd_rdata == 32'd0) begin
              irq_q <= 1'b1;
              st    <= S_IDLE;
            end else begin
              base_q <= {rd_rdata[31:2], 2'b00};
              widx_q <= '0;
              st     <= S_REQ;
            end
          end else if (widx_q[0]) begin
            ptr_q  <= rd_rdata;
            widx_q <= widx_q + WI_W'(1);
            st     <= S_REQ;
          end else begin
            len_q <= rd_rdata[LEN_W-1:0];
            dir_q <= rd_rdata[DIR_BIT];
            if (pair_used) begin
              st <= S_CMD;
            end else begin
              widx_q <= widx_q + WI_W'(1);
              st     <= S_REQ;
            end
          end
        end
        S_CMD: if (cmd_ready) begin
          widx_q <= widx_q + WI_W'(1);
          st     <= S_REQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_walker_chk.sv
`timescale 1ns/1ps
module desc_walker_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic [31:0]      rd_addr,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [31:0]      cmd_addr,
  input logic [LEN_W-1:0] cmd_len,
  input logic [2:0]       cmd_idx,
  input logic             cmd_dir,
  input logic [2:0]       cmd_cat,
  input logic [1:0]       cmd_type,
  input logic [15:0]      cmd_ctrl,
  input logic             busy,
  input logic             irq,
  input logic             err
);
  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ((rd_addr & 32'h3) == 32'h0));

  p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)
      && $stable(cmd_idx) && $stable(cmd_dir) && $stable(cmd_cat)
      && $stable(cmd_type) && $stable(cmd_ctrl)));

  p_no_read_in_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !rd_req);

  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_idx != 3'd0));

  p_cat_known_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_cat inside {[3'd1:3'd4]}));

  p_err_with_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> irq);

  p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  p_irq_clear_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> busy);
endmodule

bind desc_walker desc_walker_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/desc_walker_tb.sv
`timescale 1ns/1ps
module desc_walker_tb;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] start_ptr = '0;
  logic rd_req;
  logic [31:0] rd_addr;
  logic rd_rvalid = 1'b0;
  logic [31:0] rd_rdata = '0;
  logic cmd_valid;
  logic cmd_ready = 1'b0;
  logic [31:0] cmd_addr;
  logic [LEN_W-1:0] cmd_len;
  logic [2:0] cmd_idx;
  logic cmd_dir;
  logic [2:0] cmd_cat;
  logic [1:0] cmd_type;
  logic [15:0] cmd_ctrl;
  logic busy, irq, err;

  always #2.5 clk = ~clk;

  desc_walker #(.LEN_W(LEN_W)) u_dut (.*);

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [64];
  int lat_cfg = 0;
  int rdy_mode = 0;
  logic [7:0] lfsr = 8'h5A;
  bit pend = 0;
  int cnt = 0;
  logic [31:0] raddr = '0;

  logic [31:0] rd_log [80];
  int n_rd = 0;
  logic [31:0] g_addr [40];
  logic [31:0] g_len [40];
  logic [2:0]  g_idx [40];
  logic        g_dir [40];
  logic [2:0]  g_cat [40];
  logic [1:0]  g_typ [40];
  logic [15:0] g_ctl [40];
  int n_got = 0;

  logic [31:0] e_rd [80];
  int n_erd = 0;
  logic [31:0] e_addr [40];
  logic [31:0] e_len [40];
  logic [2:0]  e_idx [40];
  logic        e_dir [40];
  logic [2:0]  e_cat [40];
  logic [1:0]  e_typ [40];
  logic [15:0] e_ctl [40];
  int n_exp = 0;

  bit p_valid = 0, p_ready = 0;
  logic [31:0] p_addr;
  logic [LEN_W-1:0] p_len;
  logic [2:0] p_idx;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cmd_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
    rd_rvalid = 1'b0;
    if (!rst_n) begin
      pend = 0;
      p_valid = 0;
    end else begin
      if (pend) begin
        if (cnt == 0) begin
          rd_rvalid = 1'b1;
          rd_rdata = mem[raddr[7:2]];
          pend = 0;
        end else cnt--;
      end
      if (rd_req) begin
        if (pend) chk(0, "R2", "read issued before response", 1, 0);
        if (cmd_valid) chk(0, "R5", "read during pending command", 1, 0);
        if (n_rd < 80) rd_log[n_rd] = rd_addr;
        n_rd++;
        pend = 1;
        cnt = lat_cfg;
        raddr = rd_addr;
      end
      if (p_valid && !p_ready) begin
        chk(cmd_valid && cmd_addr == p_addr && cmd_len == p_len && cmd_idx == p_idx,
            "R5", "command changed before accept", {cmd_valid, cmd_idx}, {1'b1, p_idx});
      end
      if (cmd_valid && cmd_ready && n_got < 40) begin
        g_addr[n_got] = cmd_addr; g_len[n_got] = 32'(cmd_len); g_idx[n_got] = cmd_idx;
        g_dir[n_got] = cmd_dir; g_cat[n_got] = cmd_cat; g_typ[n_got] = cmd_type;
        g_ctl[n_got] = cmd_ctrl;
      end
      if (cmd_valid && cmd_ready) n_got++;
      p_valid = cmd_valid; p_ready = cmd_ready;
      p_addr = cmd_addr; p_len = cmd_len; p_idx = cmd_idx;
    end
  end

  function automatic logic [31:0] pptr(input logic [31:0] b, input int k);
    return 32'hC000_0000 | (b << 8) | (32'(k) << 4);
  endfunction

  function automatic logic [31:0] plen(input int k);
    return (32'(k & 1) << 31) | 32'h0055_0000 | 32'(k * 12);
  endfunction

  task automatic clear_exp();
    n_erd = 0;
    n_exp = 0;
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] hdr,
                          input logic [31:0] nxt, output bit ok);
    int w;
    int np;
    w = int'(base[7:2]);
    np = int'(hdr[18:16]);
    ok = (hdr[31:29] >= 3'd1) && (hdr[31:29] <= 3'd4) && (np != 0);
    mem[w] = hdr;
    for (int k = 1; k <= 7; k++) begin
      mem[w + 2*k - 1] = pptr(base, k);
      mem[w + 2*k]     = plen(k);
    end
    mem[w + 15] = nxt;
    if (ok) begin
      for (int i = 0; i < 16; i++) begin e_rd[n_erd] = base + 32'(4*i); n_erd++; end
      for (int k = 1; k <= np; k++) begin
        e_addr[n_exp] = pptr(base, k); e_len[n_exp] = 32'(k * 12); e_idx[n_exp] = 3'(k);
        e_dir[n_exp] = k[0]; e_cat[n_exp] = hdr[31:29]; e_typ[n_exp] = hdr[27:26];
        e_ctl[n_exp] = hdr[15:0];
        n_exp++;
      end
    end else begin
      e_rd[n_erd] = base; n_erd++;
    end
  endtask

  task automatic run(input logic [31:0] sp, input int lat, input int rm,
                     input bit eerr, input logic [31:0] mid_ptr);
    lat_cfg = lat; rdy_mode = rm; n_rd = 0; n_got = 0;
    @(negedge clk); start = 1'b1; start_ptr = sp;
    @(negedge clk); start = 1'b0;
    chk(!irq && busy, "R8", "irq clear and busy after start", {irq, busy}, 2'b01);
    for (int c = 0; c < 4000; c++) begin
      if (!busy) break;
      @(negedge clk);
      start = (c == 6 && mid_ptr != 0);
      start_ptr = mid_ptr;
    end
    start = 1'b0;
    chk(!busy, "R6", "walk finished", busy, 0);
    chk(n_rd == n_erd, "R9", "read count", n_rd, n_erd);
    for (int i = 0; i < n_erd && i < n_rd; i++)
      chk(rd_log[i] == e_rd[i], "R2", $sformatf("read address %0d", i), rd_log[i], e_rd[i]);
    chk(n_got == n_exp, "R4", "command count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(g_addr[i] == e_addr[i] && g_idx[i] == e_idx[i], "R4",
          $sformatf("cmd %0d addr/idx", i), {g_addr[i], 1'b0, g_idx[i]}, {e_addr[i], 1'b0, e_idx[i]});
      chk(g_len[i] == e_len[i] && g_dir[i] == e_dir[i], "R4",
          $sformatf("cmd %0d len/dir", i), {g_dir[i], g_len[i]}, {e_dir[i], e_len[i]});
      chk(g_cat[i] == e_cat[i] && g_typ[i] == e_typ[i] && g_ctl[i] == e_ctl[i], "R3",
          $sformatf("cmd %0d header fields", i), {g_cat[i], g_typ[i], g_ctl[i]},
          {e_cat[i], e_typ[i], e_ctl[i]});
    end
    chk(irq == 1'b1, "R6", "irq at end", irq, 1);
    chk(err == eerr, "R7", "err flag", err, eerr);
  endtask

  // {header, latency, ready pattern}
  localparam logic [34:0] TBL [8] = '{
    {3'b001, 1'b0, 2'd1, 7'd0, 3'd3, 16'hA5A5, 2'd0, 1'b0},
    {3'b010, 1'b0, 2'd2, 7'd0, 3'd7, 16'h1234, 2'd2, 1'b1},
    {3'b011, 1'b0, 2'd0, 7'd0, 3'd1, 16'hFFFF, 2'd1, 1'b0},
    {3'b100, 1'b0, 2'd3, 7'd0, 3'd2, 16'h0F0F, 2'd3, 1'b1},
    {3'b000, 1'b0, 2'd1, 7'd0, 3'd2, 16'h1111, 2'd0, 1'b0},
    {3'b101, 1'b0, 2'd0, 7'd0, 3'd4, 16'h2222, 2'd1, 1'b1},
    {3'b001, 1'b0, 2'd1, 7'd0, 3'd0, 16'h3333, 2'd0, 1'b0},
    {3'b111, 1'b0, 2'd2, 7'd0, 3'd7, 16'h4444, 2'd2, 1'b0}
  };

  initial begin
    #900_000;
    checks++; errors++;
    $display("FAIL watchdog: run did not end, actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ok, ok2;
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !cmd_valid && !irq && !err, "R1", "reset state",
        {busy, rd_req, cmd_valid, irq, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int t = 0; t < 8; t++) begin
      clear_exp();
      put_desc(32'h40, TBL[t][34:3], 32'h0, ok);
      run(32'h40, int'(TBL[t][2:1]), int'(TBL[t][0]), !ok, 32'h0);
    end

    // R6 chain with unaligned link, R8 start ignored while busy
    clear_exp();
    put_desc(32'h40, {3'b001, 1'b0, 2'd2, 7'd0, 3'd2, 16'hBEEF}, 32'h83, ok);
    put_desc(32'h80, {3'b010, 1'b0, 2'd1, 7'd0, 3'd5, 16'hCAFE}, 32'h0, ok2);
    mem[48] = 32'h0;
    run(32'h40, 1, 1, 1'b0, 32'hC0);

    // R2 unaligned start pointer
    clear_exp();
    put_desc(32'h40, {3'b100, 1'b0, 2'd0, 7'd0, 3'd6, 16'h5A5A}, 32'h0, ok);
    run(32'h42, 0, 0, 1'b0, 32'h0);

    // R8 flags hold while idle
    repeat (10) @(negedge clk);
    chk(irq && !err && !busy, "R8", "irq held while idle", {irq, err, busy}, 3'b100);

    // R1 reset in the middle of a walk
    clear_exp();
    put_desc(32'h40, {3'b001, 1'b0, 2'd0, 7'd0, 3'd7, 16'h7777}, 32'h0, ok);
    lat_cfg = 3; rdy_mode = 1;
    @(negedge clk); start = 1'b1; start_ptr = 32'h40;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !rd_req && !cmd_valid && !irq && !err, "R1", "state after mid-walk reset",
        {busy, rd_req, cmd_valid, irq, err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run(32'h40, 2, 0, 1'b0, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule